// File: doc/BRIEF.md
# Converter Clock-Enable and Timebase Tick Divider

This block turns the system clock into three single-cycle enable pulses for a converter: a main conversion-rate enable and two slower timebase ticks (nominally one every 10 µs and one every 1 ms). All three outputs are clock enables, not gated clocks. Downstream logic stays on the system clock and qualifies its work with the pulses. The main enable divides the system clock. Both timebase ticks count main-enable pulses, so each one always coincides with a main pulse.

Software computes the three divide values and places them, each stored as the ratio minus one, in a single 32-bit configuration word. A write of that word loads the ratios and restarts every counter from a clean phase. A level enable input holds all counters at zero and silences the outputs while it is low. A build parameter selects a narrower variant. In that variant the main divider has 6 bits, the 10 µs field moves to bits [23:16], and there is no millisecond tick. The block has no streaming data path, so every pin is a plain control or status signal and there is no back-pressure.

Top module: `conv_tick_divider`

## Requirements
- R1: After reset every stored ratio field is zero. With the enable low all three outputs are low. Once the enable is raised, all outputs (only two in the narrow variant) pulse on every cycle.
- R2: Default variant: cfg_wdata[7:0] holds the main ratio minus one. main_tick is high in exactly one cycle of every (field+1) cycles, for ratios 1 to 256.
- R3: Default variant: cfg_wdata[15:8] holds the 10 µs ratio minus one, counted in main_tick pulses. tick_10us is high only together with main_tick, on every (field+1)-th main pulse.
- R4: Default variant: cfg_wdata[23:16] holds the 1 ms ratio minus one, counted in main_tick pulses. tick_1ms is high only together with main_tick, on every (field+1)-th main pulse.
- R5: A field value of zero means divide-by-one: that stage's tick is high on every pulse of its input.
- R6: A cycle with cfg_we high loads the ratios and clears all counters. Counting from the cycle after that write as cycle 0, main_tick is high in cycle k exactly when (k+1) is a multiple of the main ratio. A write in the middle of a run restarts the phase the same way.
- R7: While enable is low all outputs are low and all counters are held at zero. When enable rises, the outputs follow the same phase as just after a write, starting with the cycle in which enable is first high.
- R8: Narrow variant (NARROW=1): the main ratio is cfg_wdata[5:0] and the 10 µs ratio is cfg_wdata[23:16]. Bits [7:6] and [15:8] have no effect, and tick_1ms stays low.
- R9: Default variant: cfg_wdata[31:24] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; low holds counters at zero |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Packed ratio fields, each ratio minus one |
| main_tick | output | 1 | Main converter clock-enable pulse |
| tick_10us | output | 1 | 10 µs timebase pulse |
| tick_1ms | output | 1 | 1 ms timebase pulse (always low in narrow variant) |

## Verification
The hardest case to reach is the moment where every stage reaches its terminal count at once, because it appears only after main ratio times sub ratio cycles. With a full 256 main ratio that window runs to hundreds of cycles. The bench therefore runs long windows with a maximum main field. It also uses mismatched small ratios such as 3, 4 and 7, so that the coincident tick lands at an irregular cycle. A second way to disturb the phase is to rewrite the configuration or drop the enable partway through a period. The bench does both and then checks that the whole pattern restarts from cycle zero.

// File: rtl/conv_tick_pkg.sv
package conv_tick_pkg;
  localparam int FIELD_W       = 8;
  localparam int NARROW_MAIN_W = 6;
  localparam int MAIN_LSB      = 0;
  localparam int WIDE_SUB_LSB  = 8;
  localparam int NARROW_SUB_LSB = 16;
  localparam int MILLI_LSB     = 16;

  function automatic int main_width(input bit narrow);
    return narrow ? NARROW_MAIN_W : FIELD_W;
  endfunction

  function automatic int sub_lsb(input bit narrow);
    return narrow ? NARROW_SUB_LSB : WIDE_SUB_LSB;
  endfunction
endpackage

// File: rtl/conv_tick_stage.sv
module conv_tick_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic         in_tick,
  input  logic [W-1:0] ratio,
  output logic         out_tick
);
  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end   = (cnt_q == ratio);
  assign out_tick = run && in_tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || !run)  cnt_q <= '0;
    else if (in_tick)          cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ratio);

  p_div_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && in_tick && ratio == '0) |-> out_tick);
endmodule

// File: rtl/conv_tick_divider.sv
module conv_tick_divider
  import conv_tick_pkg::*;
#(
  parameter bit NARROW = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic        main_tick,
  output logic        tick_10us,
  output logic        tick_1ms
);
  localparam int MAIN_W  = main_width(NARROW);
  localparam int SUB_LSB = sub_lsb(NARROW);

  logic [MAIN_W-1:0]  main_q;
  logic [FIELD_W-1:0] sub_q;
  logic [MAIN_W-1:0]  gap_q;
  logic               unused_cfg;

  assign unused_cfg = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      sub_q  <= '0;
    end else if (cfg_we) begin
      main_q <= cfg_wdata[MAIN_LSB +: MAIN_W];
      sub_q  <= cfg_wdata[SUB_LSB +: FIELD_W];
    end
  end

  conv_tick_stage #(.W(MAIN_W)) u_main (
    .clk(clk), .rst_n(rst_n), .run(enable), .restart(cfg_we),
    .in_tick(1'b1), .ratio(main_q), .out_tick(main_tick));

  conv_tick_stage #(.W(FIELD_W)) u_sub (
    .clk(clk), .rst_n(rst_n), .run(enable), .restart(cfg_we),
    .in_tick(main_tick), .ratio(sub_q), .out_tick(tick_10us));

  generate
    if (!NARROW) begin : g_milli
      logic [FIELD_W-1:0] milli_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      milli_q <= '0;
        else if (cfg_we) milli_q <= cfg_wdata[MILLI_LSB +: FIELD_W];
      end
      conv_tick_stage #(.W(FIELD_W)) u_milli (
        .clk(clk), .rst_n(rst_n), .run(enable), .restart(cfg_we),
        .in_tick(main_tick), .ratio(milli_q), .out_tick(tick_1ms));

      p_milli_on_main_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1ms |-> main_tick);
    end else begin : g_no_milli
      assign tick_1ms = 1'b0;
    end
  endgenerate

  // Independent cycle count since the last main pulse, used only for checking.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              gap_q <= '0;
    else if (!enable || cfg_we || main_tick) gap_q <= '0;
    else                                     gap_q <= gap_q + 1'b1;
  end

  p_main_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && main_tick) |-> (gap_q == main_q));

  p_sub_on_main_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_10us |-> main_tick);

  p_restart_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(cfg_we)) |-> (main_tick == (main_q == '0)));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !(main_tick || tick_10us || tick_1ms));
endmodule

// File: tb/conv_tick_divider_test.sv
module conv_tick_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        w_main, w_sub, w_milli;
  logic        n_main, n_sub, n_milli;
  int          n_checks = 0;
  int          n_fail = 0;
  logic [31:0] last_cfg = '0;

  always #4 clk = ~clk;

  conv_tick_divider #(.NARROW(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .main_tick(w_main), .tick_10us(w_sub), .tick_1ms(w_milli));

  conv_tick_divider #(.NARROW(1'b1)) uut_n (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .main_tick(n_main), .tick_10us(n_sub), .tick_1ms(n_milli));

  function automatic bit due(input int k, input int p);
    return ((k + 1) % p) == 0;
  endfunction

  task automatic check3(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ticks{main,10us,1ms} actual %b expected %b", tag, act, exp);
    end
  endtask

  // Checks K cycles starting at phase 0 (current negedge).
  task automatic window(input int kmax, input string tag);
    int wm, ws, wl, nm, ns;
    wm = int'(last_cfg[7:0]) + 1;
    ws = int'(last_cfg[15:8]) + 1;
    wl = int'(last_cfg[23:16]) + 1;
    nm = int'(last_cfg[5:0]) + 1;
    ns = int'(last_cfg[23:16]) + 1;
    for (int k = 0; k < kmax; k++) begin
      #1;
      check3({tag, " wide"}, {w_main, w_sub, w_milli},
             {due(k, wm), due(k, wm * ws), due(k, wm * wl)});
      check3({tag, " narrow R8"}, {n_main, n_sub, n_milli},
             {due(k, nm), due(k, nm * ns), 1'b0});
      @(negedge clk);
    end
  endtask

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = 32'hDEAD_BEEF;
    last_cfg = v;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) begin
      #1;
      check3("R1 R7 reset idle", {w_main, w_sub, w_milli}, 3'b000);
      check3("R1 R7 reset idle narrow", {n_main, n_sub, n_milli}, 3'b000);
      @(negedge clk);
    end
    enable = 1'b1;
    window(6, "R1 R5 reset ratios");
  endtask

  task automatic t_ratios;
    write_cfg(32'h0014_0409);
    window(450, "R2 R3 R4 R6");
  endtask

  task automatic t_odd;
    write_cfg(32'hAB06_0302);
    window(120, "R2 R3 R4 R9");
  endtask

  task automatic t_big;
    write_cfg(32'h0002_01FF);
    window(800, "R2 R8 full main ratio");
  endtask

  task automatic t_unity;
    write_cfg(32'h5A00_0000);
    window(8, "R5 R9 unity");
  endtask

  task automatic t_rewrite;
    write_cfg(32'h0005_0306);
    for (int i = 0; i < 37; i++) @(negedge clk);
    write_cfg(32'h0003_0204);
    window(90, "R6 mid-run rewrite");
  endtask

  task automatic t_enable;
    write_cfg(32'h0003_0204);
    for (int i = 0; i < 23; i++) @(negedge clk);
    enable = 1'b0;
    for (int i = 0; i < 10; i++) begin
      #1;
      check3("R7 disabled", {w_main, w_sub, w_milli}, 3'b000);
      check3("R7 disabled narrow", {n_main, n_sub, n_milli}, 3'b000);
      @(negedge clk);
    end
    enable = 1'b1;
    window(90, "R7 re-enable");
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ratios();
    t_odd();
    t_big();
    t_unity();
    t_rewrite();
    t_enable();
    finish_run();
  end
endmodule